// File: doc/BRIEF.md
# PCM Sample Injection Path

This block sits between the FM channel pipeline and the shared DAC accumulation path of an FM synthesis core. Software loads a 9-bit PCM sample through two register writes: a full byte that supplies the upper eight bits and a second register whose bit 3 supplies the least significant bit. The assembled value is kept in a holding register that changes on the cycle after the write. It does not wait for the slot sequence to reach it.

Every clock is one FM tick, and an external counter names the current position (0 to 23) in the 24-tick output frame. When PCM is enabled, the block replaces the sixth channel's result with the held sample at that channel's fixed output position, once per frame. Every other position passes the FM result through. The sample's top bit is inverted on the way out, which turns the offset-binary sample into a two's-complement value that sums correctly with the FM channels. A test bit makes the block drive the sample in every position of the frame. The output is registered and has one tick of latency.

Because the sample is only read once per frame, a sample rate that is not a whole multiple of 24 ticks produces uneven holds. At a 36-tick write pace, successive samples last 2 frames and 1 frame in turn.

Top module: `pcm_inject`

## Requirements
- R1: While `rst_n` is low, `mix_out` is 0 and `pcm_drive` is 0, and the held sample is cleared to 0.
- R2: A cycle with `pcm_hi_we` high loads `reg_wdata[7:0]` into sample bits [8:1].
- R3: A cycle with `pcm_lo_we` high loads `reg_wdata[3]` into sample bit [0]; the other `reg_wdata` bits have no effect on the sample.
- R4: When driven, the sample appears on `mix_out` as {~s[8], s[7:0]}, so the top bit is inverted.
- R5: A write is visible at the output in any selected position whose inputs arrive on the cycle right after the write. The hold has no frame-aligned delay.
- R6: With `pcm_en`=1 and `dac_loud`=0, the sample is driven only when `slot_idx` equals 5 (the sixth channel's position). In every other position, `mix_out` equals `fm_value` and `pcm_drive` is 0.
- R7: With `pcm_en`=0, every position passes `fm_value` to `mix_out` and `pcm_drive` is 0, whatever `dac_loud` is.
- R8: With `pcm_en`=1 and `dac_loud`=1, the sample is driven in every position and `pcm_drive` is 1.
- R9: The output is registered: the inputs of cycle k determine `mix_out` and `pcm_drive` after the clock edge that ends cycle k.
- R10: Samples written every 24 ticks each appear in exactly one frame. Samples written every 36 ticks appear for 2 frames and 1 frame in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | FM tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wdata | input | 8 | Register write data bus |
| pcm_hi_we | input | 1 | Write strobe for the sample's upper-byte register |
| pcm_lo_we | input | 1 | Write strobe for the register holding the sample LSB in bit 3 |
| pcm_en | input | 1 | PCM substitution enable |
| dac_loud | input | 1 | Test bit: drive the sample in every position |
| slot_idx | input | 5 | Current position in the 24-tick frame (0..23) |
| fm_value | input | 9 | FM result for the current position |
| mix_out | output | 9 | Signed value to the DAC accumulation path |
| pcm_drive | output | 1 | High when `mix_out` carries the PCM sample |

## Verification
Each cycle, the assertions check the pass-through when PCM is disabled and the pass-through outside the sixth channel's position. They also check that the loud test bit drives the sample in every position, and that a freshly written upper byte appears with its top bit inverted one tick after the write. The bench's scenarios are needed to show the effects that build up over many frames: the LSB register ignoring its other bits, the one-frame-per-sample sequence at a 24-tick pace, and the alternating 2-and-1 frame holds at a 36-tick pace. The bench also compares every cycle of randomized enable, test-bit, slot and write traffic against its own model.

// File: rtl/pcm_inject_pkg.sv
// Package: shared helpers for the PCM injection path.
// Assumes samples are offset binary and the DAC path sums two's complement.
package pcm_inject_pkg;

    // Convert an offset-binary sample to two's complement by flipping its MSB.
    function automatic logic [8:0] offset_to_signed(input logic [8:0] s);
        offset_to_signed = {~s[8], s[7:0]};
    endfunction

endpackage

// File: rtl/pcm_hold_reg.sv
// Module: pcm_hold_reg
// Holds the PCM sample. The upper bits come from a full byte write, and the LSB
// comes from one bit of a second register write. The register updates on the
// edge that ends the write cycle. It assumes both strobes may be high together
// and that they then update disjoint bits.
module pcm_hold_reg #(
    parameter int SAMPLE_W = 9,
    parameter int LSB_BIT  = 3,
    localparam int BYTE_W  = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hi_we,
    input  logic                lo_we,
    input  logic [BYTE_W-1:0]   wdata,
    output logic [SAMPLE_W-1:0] sample
);

    // Capture the upper bits on a byte write.
    always_ff @(posedge clk) begin
        if (!rst_n)     sample[SAMPLE_W-1:1] <= '0;
        else if (hi_we) sample[SAMPLE_W-1:1] <= wdata;
    end

    // Capture the LSB from its bit of the second register.
    always_ff @(posedge clk) begin
        if (!rst_n)     sample[0] <= 1'b0;
        else if (lo_we) sample[0] <= wdata[LSB_BIT];
    end

endmodule

// File: rtl/pcm_slot_gate.sv
// Module: pcm_slot_gate
// Decides whether the current frame position takes the PCM sample: the PCM
// channel's own position when enabled, or every position with the loud test bit.
// It assumes slot_idx already counts 0..SLOTS-1.
module pcm_slot_gate #(
    parameter int SLOTS    = 24,
    parameter int PCM_SLOT = 5,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input  logic              pcm_en,
    input  logic              loud,
    input  logic [SLOT_W-1:0] slot_idx,
    output logic              take_pcm
);

    localparam logic [SLOT_W-1:0] PCM_POS = SLOT_W'(PCM_SLOT);

    // Select the sample only while enabled, either at its position or everywhere.
    always_comb begin
        take_pcm = pcm_en && (loud || (slot_idx == PCM_POS));
    end

endmodule

// File: rtl/pcm_out_stage.sv
// Module: pcm_out_stage
// Registered output multiplexer. It passes the FM result or the converted PCM
// sample toward the DAC path and flags which one it chose. One tick of latency.
module pcm_out_stage #(
    parameter int SAMPLE_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take_pcm,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [SAMPLE_W-1:0] fm_value,
    output logic [SAMPLE_W-1:0] mix_out,
    output logic                drive
);

    import pcm_inject_pkg::*;

    // Register the chosen value and its source flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_out <= '0;
            drive   <= 1'b0;
        end else begin
            mix_out <= take_pcm ? offset_to_signed(sample) : fm_value;
            drive   <= take_pcm;
        end
    end

endmodule

// File: rtl/pcm_inject.sv
// Module: pcm_inject (top)
// Substitutes a register-loaded PCM sample for the sixth channel's result at
// its position in the 24-tick frame. It assumes one clock per FM tick and an
// external position counter.
module pcm_inject #(
    parameter int SAMPLE_W = 9,
    parameter int SLOTS    = 24,
    parameter int PCM_SLOT = 5,
    parameter int LSB_BIT  = 3,
    localparam int SLOT_W  = $clog2(SLOTS),
    localparam int BYTE_W  = SAMPLE_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   reg_wdata,
    input  logic                pcm_hi_we,
    input  logic                pcm_lo_we,
    input  logic                pcm_en,
    input  logic                dac_loud,
    input  logic [SLOT_W-1:0]   slot_idx,
    input  logic [SAMPLE_W-1:0] fm_value,
    output logic [SAMPLE_W-1:0] mix_out,
    output logic                pcm_drive
);

    logic [SAMPLE_W-1:0] held;
    logic                take_pcm;

    pcm_hold_reg #(.SAMPLE_W(SAMPLE_W), .LSB_BIT(LSB_BIT)) i_hold (
        .clk(clk), .rst_n(rst_n), .hi_we(pcm_hi_we), .lo_we(pcm_lo_we),
        .wdata(reg_wdata), .sample(held)
    );

    pcm_slot_gate #(.SLOTS(SLOTS), .PCM_SLOT(PCM_SLOT)) i_gate (
        .pcm_en(pcm_en), .loud(dac_loud), .slot_idx(slot_idx), .take_pcm(take_pcm)
    );

    pcm_out_stage #(.SAMPLE_W(SAMPLE_W)) i_out (
        .clk(clk), .rst_n(rst_n), .take_pcm(take_pcm), .sample(held),
        .fm_value(fm_value), .mix_out(mix_out), .drive(pcm_drive)
    );

endmodule

// File: rtl/pcm_inject_chk.sv
// Module: pcm_inject_chk
// Assertion checker attached to pcm_inject by the bind below. It observes only
// the top module's ports.
module pcm_inject_chk #(
    parameter int SLOTS    = 24,
    parameter int PCM_SLOT = 5,
    localparam int SLOT_W  = $clog2(SLOTS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [7:0]        reg_wdata,
    input logic              pcm_hi_we,
    input logic              pcm_lo_we,
    input logic              pcm_en,
    input logic              dac_loud,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [8:0]        fm_value,
    input logic [8:0]        mix_out,
    input logic              pcm_drive
);

    localparam logic [SLOT_W-1:0] PCM_POS = SLOT_W'(PCM_SLOT);

    // R7: disabled PCM passes FM through and never flags drive.
    a_r7_pass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pcm_en |=> (mix_out == $past(fm_value)) && !pcm_drive);

    // R6: outside its position, and without the loud bit, FM passes through.
    a_r6_only_own_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_en && !dac_loud && slot_idx != PCM_POS) |=> (mix_out == $past(fm_value)) && !pcm_drive);

    // R8: the loud test bit drives the sample in every position.
    a_r8_loud_every_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_en && dac_loud) |=> pcm_drive);

    // R2, R4, R5: an upper-byte write shows on the next driven tick with its top bit inverted.
    a_r4_msb_inverted: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_hi_we ##1 (pcm_en && dac_loud) |=>
            (mix_out[8] == ~$past(reg_wdata[7], 2)) && (mix_out[7:1] == $past(reg_wdata[6:0], 2)));

    // R1: the outputs are cleared on the edge after a reset cycle.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (mix_out == 9'd0) && !pcm_drive);

    // The lo strobe is observed here only so that every port is connected.
    logic unused_lo;
    always_comb unused_lo = pcm_lo_we;

endmodule

bind pcm_inject pcm_inject_chk #(.SLOTS(SLOTS), .PCM_SLOT(PCM_SLOT)) i_chk (
    .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata), .pcm_hi_we(pcm_hi_we),
    .pcm_lo_we(pcm_lo_we), .pcm_en(pcm_en), .dac_loud(dac_loud),
    .slot_idx(slot_idx), .fm_value(fm_value), .mix_out(mix_out), .pcm_drive(pcm_drive)
);

// File: tb/test_pcm_inject.sv
// Bench for pcm_inject: directed corner cases and fixed-seed random traffic,
// compared each cycle against a model kept in the bench, plus frame-run checks.
module test_pcm_inject;

    localparam int PCM_SLOT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       pcm_hi_we = 1'b0, pcm_lo_we = 1'b0, pcm_en = 1'b0, dac_loud = 1'b0;
    logic [4:0] slot_idx = '0;
    logic [8:0] fm_value = '0;
    logic [8:0] mix_out;
    logic       pcm_drive;

    pcm_inject i_pcm_inject (
        .clk(clk), .rst_n(rst_n), .reg_wdata(reg_wdata), .pcm_hi_we(pcm_hi_we),
        .pcm_lo_we(pcm_lo_we), .pcm_en(pcm_en), .dac_loud(dac_loud),
        .slot_idx(slot_idx), .fm_value(fm_value), .mix_out(mix_out), .pcm_drive(pcm_drive)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_checks = 0, n_fail = 0;
    logic [8:0] model_hold = '0;     // bench copy of the held sample
    logic [8:0] exp_out;
    logic       exp_drv;
    logic       have_exp = 1'b0;
    string      exp_tag;
    int         slot_cnt = 0;
    logic       rec_on = 1'b0, rec_pending = 1'b0;
    logic [8:0] rec [0:63];
    int         n_rec = 0;
    bit         done = 1'b0;

    // Compare one actual value with its expected value and count the result.
    task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One tick: check the previous cycle's result, then drive new inputs and predict.
    task automatic step(input bit en, input bit loud, input bit hwe, input bit lwe,
                        input logic [7:0] wd, input string tag);
        logic sel;
        @(negedge clk);
        if (have_exp) check(exp_tag, {pcm_drive, mix_out}, {exp_drv, exp_out});
        if (rec_pending && n_rec < 64) begin
            rec[n_rec] = mix_out;
            n_rec++;
        end
        pcm_en = en; dac_loud = loud; pcm_hi_we = hwe; pcm_lo_we = lwe; reg_wdata = wd;
        slot_idx = 5'(slot_cnt);
        fm_value = 9'($urandom);
        sel = en && (loud || slot_cnt == PCM_SLOT);
        exp_drv = sel;
        exp_out = sel ? {~model_hold[8], model_hold[7:0]} : fm_value;
        exp_tag = tag;
        have_exp = 1'b1;
        rec_pending = rec_on && sel && !loud;
        if (hwe) model_hold[8:1] = wd;
        if (lwe) model_hold[0] = wd[3];
        slot_cnt = (slot_cnt + 1) % 24;
    endtask

    // Check the run lengths of the recorded per-frame values against the pace.
    task automatic check_runs(input int pace, input string tag);
        int runs [0:63];
        int nr = 1;
        runs[0] = 1;
        for (int i = 1; i < n_rec; i++) begin
            if (rec[i] == rec[i-1]) runs[nr-1]++;
            else begin runs[nr] = 1; nr++; end
        end
        // The first and last runs may be partial and are skipped.
        for (int i = 1; i < nr - 1; i++) begin
            if (pace == 24) check(tag, 10'(runs[i]), 10'd1);
            else if (i > 1) check(tag, 10'(runs[i] + runs[i-1]), 10'd3);
        end
        check({tag, " run count"}, 10'(nr > 4), 10'd1);
    endtask

    initial begin
        void'($urandom(32'd2024));
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 reset", {pcm_drive, mix_out}, 10'd0);
        @(negedge clk); rst_n = 1'b1;
        slot_cnt = 0;

        // R2, R4: load a known byte, then drive it with the loud bit.
        step(1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, "R7 disabled");
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R2 R4 loud hold");
        // R3: a LSB-register write with bit 3 clear and all others set.
        step(1'b1, 1'b1, 1'b0, 1'b1, 8'hF7, "R8 loud");
        step(1'b1, 1'b1, 1'b0, 1'b1, 8'h08, "R3 lsb bits ignored");
        step(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, "R3 lsb set");
        // R7: the loud bit has no effect while disabled.
        for (int i = 0; i < 24; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7 loud but disabled");
        // R6, R5: a write in each position just before the PCM position.
        for (int i = 0; i < 48; i++)
            step(1'b1, 1'b0, (slot_cnt == PCM_SLOT - 1), 1'b0, 8'(i), "R5 R6 R9 own slot");
        // Random traffic.
        for (int i = 0; i < 600; i++)
            step(1'(($urandom % 4) != 0), 1'(($urandom % 5) == 0), 1'(($urandom % 6) == 0),
                 1'(($urandom % 6) == 0), 8'($urandom), "R6 R7 R8 random");

        // R10: 24-tick pace.
        n_rec = 0; rec_on = 1'b1;
        for (int i = 0; i < 24 * 12; i++)
            step(1'b1, 1'b0, (i % 24 == 7), 1'b0, 8'(i / 24 + 1), "R10 pace24");
        rec_on = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R10 pace24 tail");
        check_runs(24, "R10 pace24 runs");

        // R10: 36-tick pace.
        n_rec = 0; rec_on = 1'b1;
        for (int i = 0; i < 24 * 18; i++)
            step(1'b1, 1'b0, (i % 36 == 3), 1'b0, 8'(i / 36 + 40), "R10 pace36");
        rec_on = 1'b0;
        step(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R10 pace36 tail");
        check_runs(36, "R10 pace36 runs");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule